// File: doc/BRIEF.md
# DDR I/Q Interleaved Data Capture

This block receives a 16-bit parallel bus running at double data rate. Each bus word is either an in-phase (I) or a quadrature (Q) sample. The words arrive interleaved as I, Q, I, Q. A sampling clock latches the bus on both of its edges. Alongside the data comes a strobe lane that is captured exactly like a data bit. The strobe alternates every half period, and its level tells which channel the word beside it belongs to.

The block turns the two words captured in each sampling period into an ordered pair, where the rising-edge word comes first. It steers each word by its strobe level and holds an I word until the next Q word arrives. Each complete pair goes through a two-entry register stage into the converter clock domain. There the pair appears on two sample outputs with a one-cycle valid pulse. A sticky flag reports any break in the strobe's alternation, and pairing then resynchronises on the next I word.

Top module: `ddr_iq_capture`

## Requirements
- R1: Words are captured on both edges of `samp_clk`, and the rising-edge word is treated as earlier in the stream than the falling-edge word that follows it.
- R2: A word captured with `strobe` = 1 is an I word and one with `strobe` = 0 is a Q word. A valid output presents the I word on `i_out` and the Q word that followed it on `q_out`.
- R3: `out_valid` pulses once per I/Q pair. A continuous, correctly alternating stream yields one pair on every converter cycle, with none lost or reordered.
- R4: After reset `out_valid` and `frame_err` are 0, and `out_valid` stays 0 until a complete I/Q pair has been captured.
- R5: A Q word that arrives with no I word pending, as the first word after reset, is discarded without raising `frame_err`.
- R6: Two consecutive words with the same strobe level set `frame_err`, which then stays 1 until reset.
- R7: When an I word follows an I word, the later one replaces the pending one and pairs with the next Q word.
- R8: When a Q word follows a Q word, the second Q is discarded and produces no output.
- R9: A pair whose I word is captured on a falling edge and whose Q word is captured on the next rising edge is emitted correctly.
- R10: While `out_valid` is 0, `i_out` and `q_out` hold the last emitted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Sampling clock; bus captured on both edges |
| conv_clk | input | 1 | Converter clock, frequency-locked to samp_clk |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Double-data-rate sample bus |
| strobe | input | 1 | Channel strobe lane: 1 = I word, 0 = Q word |
| i_out | output | 16 | I sample of the current pair |
| q_out | output | 16 | Q sample of the current pair |
| out_valid | output | 1 | One-cycle pulse per emitted pair |
| frame_err | output | 1 | Sticky strobe-alternation error |

## Verification
The assertions take the following for granted:
- `conv_clk` runs at the same frequency as `samp_clk`, with enough phase margin that a pair written on one edge can be read on the next converter edge.
- The bus and strobe hold steady around each sampling edge.

The stimulus meets both conditions by driving the two clock inputs from one clock. It changes the bus a quarter period after each edge, so each word sits mid-window.

A stream stays clean only while the strobe keeps alternating. For that reason the stimulus keeps alternating filler words running after each scenario until reset. Its strobe levels break only where a framing fault is deliberately injected.

// File: rtl/ddr_iq_pkg.sv
package ddr_iq_pkg;

    localparam int SAMPLE_W     = 16;
    localparam int RETIME_DEPTH = 2;
    localparam int LANES        = 2;   // words per sampling period

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic    is_i;
        sample_t data;
    } lane_word_t;

    typedef struct packed {
        sample_t i;
        sample_t q;
    } iq_pair_t;

    function automatic lane_word_t make_word(input logic lvl, input sample_t d);
        lane_word_t w;
        w.is_i = lvl;
        w.data = d;
        return w;
    endfunction

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/ddr_word_capture.sv
module ddr_word_capture
    import ddr_iq_pkg::*;
(
    input  logic       samp_clk,
    input  logic       rst,
    input  sample_t    din,
    input  logic       strobe,
    output lane_word_t word_early,
    output lane_word_t word_late,
    output logic       words_valid
);
    lane_word_t rise_q;
    lane_word_t fall_q;
    logic       rise_ok;

    // rising-edge flop: first word of the period
    always_ff @(posedge samp_clk) begin
        if (rst) begin
            rise_q  <= '0;
            rise_ok <= 1'b0;
        end else begin
            rise_q  <= make_word(strobe, din);
            rise_ok <= 1'b1;
        end
    end

    // falling-edge flop: second word of the period
    always_ff @(negedge samp_clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= make_word(strobe, din);
        end
    end

    // realign both halves onto the rising edge, early word first
    always_ff @(posedge samp_clk) begin
        if (rst) begin
            word_early  <= '0;
            word_late   <= '0;
            words_valid <= 1'b0;
        end else begin
            word_early  <= rise_q;
            word_late   <= fall_q;
            words_valid <= rise_ok;
        end
    end
endmodule

// File: rtl/iq_pairer.sv
module iq_pairer
    import ddr_iq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  lane_word_t word_early,
    input  lane_word_t word_late,
    output logic       pair_valid,
    output iq_pair_t   pair,
    output logic       frame_err
);
    logic    hold_v, last_v, last_lvl;
    sample_t hold_d;

    logic     n_hold_v, n_last_v, n_last_lvl, n_err, n_emit;
    sample_t  n_hold_d;
    iq_pair_t n_pair;
    lane_word_t seq_w [LANES];

    always_comb begin
        seq_w[0] = word_early;
        seq_w[1] = word_late;
    end

    // walk the period's words in stream order
    always_comb begin
        n_hold_v   = hold_v;
        n_hold_d   = hold_d;
        n_last_v   = last_v;
        n_last_lvl = last_lvl;
        n_err      = frame_err;
        n_emit     = 1'b0;
        n_pair     = pair;
        if (in_valid) begin
            for (int k = 0; k < LANES; k++) begin
                if (n_last_v && (n_last_lvl == seq_w[k].is_i)) begin
                    n_err = 1'b1;
                end
                if (seq_w[k].is_i) begin
                    n_hold_v = 1'b1;
                    n_hold_d = seq_w[k].data;
                end else if (n_hold_v) begin
                    n_emit   = 1'b1;
                    n_pair.i = n_hold_d;
                    n_pair.q = seq_w[k].data;
                    n_hold_v = 1'b0;
                end
                n_last_v   = 1'b1;
                n_last_lvl = seq_w[k].is_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v     <= 1'b0;
            hold_d     <= '0;
            last_v     <= 1'b0;
            last_lvl   <= 1'b0;
            frame_err  <= 1'b0;
            pair_valid <= 1'b0;
            pair       <= '0;
        end else begin
            hold_v     <= n_hold_v;
            hold_d     <= n_hold_d;
            last_v     <= n_last_v;
            last_lvl   <= n_last_lvl;
            frame_err  <= n_err;
            pair_valid <= n_emit;
            pair       <= n_pair;
        end
    end
endmodule

// File: rtl/iq_retimer.sv
module iq_retimer
    import ddr_iq_pkg::*;
#(
    parameter int DEPTH = RETIME_DEPTH
) (
    input  logic     wr_clk,
    input  logic     rd_clk,
    input  logic     rst,
    input  logic     wr_valid,
    input  iq_pair_t wr_pair,
    output logic     rd_valid,
    output iq_pair_t rd_pair
);
    localparam int PTR_W = ptr_width(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    iq_pair_t         slot  [DEPTH];
    logic             phase [DEPTH];
    logic             seen  [DEPTH];
    logic [PTR_W-1:0] wsel, rsel;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge wr_clk) begin
        if (rst)           wsel <= '0;
        else if (wr_valid) wsel <= step(wsel);
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge wr_clk) begin
            if (rst) begin
                slot[e]  <= '0;
                phase[e] <= 1'b0;
            end else if (wr_valid && (wsel == PTR_W'(e))) begin
                slot[e]  <= wr_pair;
                phase[e] <= ~phase[e];
            end
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rsel     <= '0;
            rd_valid <= 1'b0;
            rd_pair  <= '0;
            for (int e = 0; e < DEPTH; e++) seen[e] <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (phase[rsel] != seen[rsel]) begin
                rd_pair     <= slot[rsel];
                rd_valid    <= 1'b1;
                seen[rsel]  <= phase[rsel];
                rsel        <= step(rsel);
            end
        end
    end
endmodule

// File: rtl/ddr_iq_capture.sv
module ddr_iq_capture
    import ddr_iq_pkg::*;
#(
    parameter int DEPTH = RETIME_DEPTH
) (
    input  logic                samp_clk,
    input  logic                conv_clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                strobe,
    output logic [SAMPLE_W-1:0] i_out,
    output logic [SAMPLE_W-1:0] q_out,
    output logic                out_valid,
    output logic                frame_err
);
    lane_word_t cap_early, cap_late;
    logic       cap_valid;
    logic       pair_valid;
    iq_pair_t   pair, out_pair;

    ddr_word_capture u_cap (
        .samp_clk    (samp_clk),
        .rst         (rst),
        .din         (din),
        .strobe      (strobe),
        .word_early  (cap_early),
        .word_late   (cap_late),
        .words_valid (cap_valid)
    );

    iq_pairer u_pair (
        .clk        (samp_clk),
        .rst        (rst),
        .in_valid   (cap_valid),
        .word_early (cap_early),
        .word_late  (cap_late),
        .pair_valid (pair_valid),
        .pair       (pair),
        .frame_err  (frame_err)
    );

    iq_retimer #(.DEPTH(DEPTH)) u_retime (
        .wr_clk   (samp_clk),
        .rd_clk   (conv_clk),
        .rst      (rst),
        .wr_valid (pair_valid),
        .wr_pair  (pair),
        .rd_valid (out_valid),
        .rd_pair  (out_pair)
    );

    assign i_out = out_pair.i;
    assign q_out = out_pair.q;
endmodule

// File: rtl/ddr_iq_capture_chk.sv
module ddr_iq_capture_chk
    import ddr_iq_pkg::*;
(
    input logic       samp_clk,
    input logic       conv_clk,
    input logic       rst,
    input logic       out_valid,
    input sample_t    i_out,
    input sample_t    q_out,
    input logic       frame_err,
    input logic       pair_valid,
    input logic       cap_valid,
    input lane_word_t cap_early,
    input lane_word_t cap_late
);
    // R6: framing error never clears outside reset
    p_err_sticky_r6: assert property (@(posedge samp_clk) disable iff (rst)
        $past(frame_err) |-> frame_err);

    // R6: a framing error only appears after words were captured
    p_err_needs_words_r6: assert property (@(posedge samp_clk) disable iff (rst)
        $rose(frame_err) |-> $past(cap_valid));

    // R4: first converter cycle after reset is quiet
    p_quiet_out_r4: assert property (@(posedge conv_clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R4: first sampling cycle after reset has no framing error
    p_quiet_err_r4: assert property (@(posedge samp_clk) disable iff (rst)
        $past(rst) |-> !frame_err);

    // R2: a pair is only formed from a period holding a Q word
    p_pair_needs_q_r2: assert property (@(posedge samp_clk) disable iff (rst)
        pair_valid |-> $past(cap_valid && !(cap_early.is_i && cap_late.is_i)));

    // R10: outputs hold between pulses
    p_hold_out_r10: assert property (@(posedge conv_clk) disable iff (rst)
        !out_valid |-> ($stable(i_out) && $stable(q_out)));
endmodule

bind ddr_iq_capture ddr_iq_capture_chk u_chk (
    .samp_clk   (samp_clk),
    .conv_clk   (conv_clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .i_out      (i_out),
    .q_out      (q_out),
    .frame_err  (frame_err),
    .pair_valid (pair_valid),
    .cap_valid  (cap_valid),
    .cap_early  (cap_early),
    .cap_late   (cap_late)
);

// File: tb/test_ddr_iq_capture.sv
`timescale 1ns/1ps
module test_ddr_iq_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic        strobe = 1'b0;
    logic [15:0] i_out, q_out;
    logic        out_valid, frame_err;

    always #5 clk = ~clk;

    ddr_iq_capture i_ddr_iq_capture (
        .samp_clk  (clk),
        .conv_clk  (clk),
        .rst       (rst),
        .din       (din),
        .strobe    (strobe),
        .i_out     (i_out),
        .q_out     (q_out),
        .out_valid (out_valid),
        .frame_err (frame_err)
    );

    int errors = 0;
    int checks = 0;

    // reference model
    logic [31:0] exp_q[$];
    logic [31:0] last_out;
    bit          holding, have_last, last_lvl, err_exp, last_drv;
    logic [15:0] hold_d;
    int          got, exp_total, run, max_run;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model(bit s, logic [15:0] d);
        if (have_last && last_lvl == s) err_exp = 1'b1;
        if (s) begin
            hold_d  = d;
            holding = 1'b1;
        end else if (holding) begin
            exp_q.push_back({hold_d, d});
            exp_total++;
            holding = 1'b0;
        end
        have_last = 1'b1;
        last_lvl  = s;
    endtask

    // word driven a quarter period after an edge is captured on the next edge
    task automatic put(bit s, logic [15:0] d);
        @(clk);
        #2.5;
        strobe   = s;
        din      = d;
        last_drv = s;
        model(s, d);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        exp_q.delete();
        holding = 0; have_last = 0; err_exp = 0;
        got = 0; exp_total = 0; run = 0; max_run = 0;
        check(out_valid == 1'b0, "R4 valid in reset", {31'd0, out_valid}, 32'd0);
        check(frame_err == 1'b0, "R4 err in reset", {31'd0, frame_err}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic finish_scn(string req);
        int real_n;
        real_n = exp_total;
        for (int k = 0; k < 14; k++) put(~last_drv, 16'hF000 + 16'(k));
        check(frame_err == err_exp, {req, " R6 frame_err"}, {31'd0, frame_err}, {31'd0, err_exp});
        check(got >= real_n, {req, " R3 pair count"}, got, real_n);
    endtask

    // output monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                run++;
                if (run > max_run) max_run = run;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 valid without pair", {i_out, q_out}, 32'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check({i_out, q_out} == e, "R2 pair value", {i_out, q_out}, e);
                end
                last_out = {i_out, q_out};
                got++;
            end else begin
                run = 0;
                if (got > 0)
                    check({i_out, q_out} == last_out, "R10 hold", {i_out, q_out}, last_out);
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // S1 (R1, R2, R3): aligned, I on rising edge, walking ones
        do_reset();
        for (int k = 0; k < 16; k++) begin
            put(1'b1, 16'(1 << k));
            put(1'b0, 16'h8000 >> k);
        end
        finish_scn("S1 R1");
        check(max_run >= 16, "R3 sustained rate", max_run, 16);

        // S2 (R5, R9): leading Q dropped, pairs straddle periods
        do_reset();
        put(1'b0, 16'hDEAD);
        for (int k = 0; k < 10; k++) begin
            put(1'b1, 16'(k * 16'h0F0F + 3));
            put(1'b0, 16'(k * 16'h3131 + 7));
        end
        finish_scn("S2 R5 R9");
        check(frame_err == 1'b0, "R5 no error for leading Q", {31'd0, frame_err}, 32'd0);

        // S3 (R6, R7): I followed by I
        do_reset();
        for (int k = 0; k < 2; k++) begin
            put(1'b1, 16'h1000 + 16'(k));
            put(1'b0, 16'h2000 + 16'(k));
        end
        put(1'b1, 16'hAAAA);
        put(1'b1, 16'hBBBB);
        put(1'b0, 16'hCCCC);
        for (int k = 0; k < 6; k++) begin
            put(1'b1, 16'h3000 + 16'(k * 5));
            put(1'b0, 16'h4000 + 16'(k * 9));
        end
        finish_scn("S3 R7");
        check(frame_err == 1'b1, "R6 set by I-I", {31'd0, frame_err}, 32'd1);

        // S4 (R6, R8): Q followed by Q, then long clean stream stays flagged
        do_reset();
        for (int k = 0; k < 2; k++) begin
            put(1'b1, 16'h5500 + 16'(k));
            put(1'b0, 16'h6600 + 16'(k));
        end
        put(1'b0, 16'h7777);
        for (int k = 0; k < 8; k++) begin
            put(1'b1, 16'(k * 16'h1234));
            put(1'b0, ~16'(k * 16'h1234));
        end
        finish_scn("S4 R8");
        check(frame_err == 1'b1, "R6 sticky after Q-Q", {31'd0, frame_err}, 32'd1);

        // S5 (R2): extreme values
        do_reset();
        for (int k = 0; k < 8; k++) begin
            put(1'b1, (k % 2 == 0) ? 16'hFFFF : 16'h0000);
            put(1'b0, (k % 2 == 0) ? 16'h0000 : 16'hFFFF);
        end
        finish_scn("S5 R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule